// File: doc/BRIEF.md
# Energy-Checked Parity Repair for Four Parallel 16-Point Transforms

This block sits beside four 16-point transform engines that run in lockstep, and beside a fifth engine that transforms the sample-wise sum of the four main inputs. On each beat it receives one complex sample from every stream: the input and the output of each main engine, and the output of the parity engine. For each main engine it sums the squared magnitudes of the input samples and of the output samples over a frame.

The transform is unnormalised, so a healthy engine's output energy is sixteen times its input energy. The block scales the input sum by 16 and compares the two. If the absolute gap exceeds a programmable tolerance, the engine's error flag is raised.

The block stores every main output and the parity output for the whole frame. After the energy checks finish, it replays the stored frame one bin per cycle. If exactly one engine is flagged, that engine's bins are rebuilt as the parity bin minus the other three engines' bins. If two or more engines are flagged, every output goes through unchanged and an uncorrectable flag is raised.

Top module: `pcc_parity_guard`

## Requirements
- R1: For each engine k, flag bit k is set when |Eout - 16*Ein| > thresh. Eout is the sum of re^2+im^2 over the frame's 16 output samples, and Ein is the same sum over the 16 input samples. A gap exactly equal to thresh does not set the flag.
- R2: When exactly one flag bit k is set, bin i of engine k on the replay is parity[i] minus the sum of the other engines' bin i. This value is wrapped to the output width in two's complement.
- R3: If two or more flags are set, uncorrectable is 1 and every engine's replayed bin equals the stored output. An engine whose flag is clear is always replayed unchanged. Flags and uncorrectable do not change during the replay.
- R4: After frameStart, a frame consists of the next 16 cycles with sampleValid high. Cycles with sampleValid low may fall between them and are skipped. The n-th accepted beat becomes bin n-1.
- R5: Timing of the results:
  - errFlags and uncorrectable change one cycle after the 16th accepted beat.
  - In that same cycle rdValid rises for 16 consecutive cycles, with rdIndex counting 0 to 15.
  - frameDone is high for the single cycle after the last replay beat.
- R6: frameStart in any state clears errFlags and uncorrectable and drops rdValid in the next cycle, then starts a new frame collection.
- R7: After reset, errFlags, uncorrectable, rdValid and frameDone are all 0.
- R8: sampleValid has no effect while no frame is being collected, that is during the check, the replay, the done cycle or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse: clear state and begin collecting a frame |
| sampleValid | input | 1 | The sample buses carry one bin/sample this cycle |
| thresh | input | EN_W | Tolerance on the energy gap |
| inReBus | input | NUM_ENG*IN_W | Real parts of the main engines' input samples, engine 0 in the low slice |
| inImBus | input | NUM_ENG*IN_W | Imaginary parts of the main engines' input samples |
| outReBus | input | NUM_ENG*OUT_W | Real parts of the main engines' output bins |
| outImBus | input | NUM_ENG*OUT_W | Imaginary parts of the main engines' output bins |
| parRe | input | PAR_W | Real part of the parity engine's output bin |
| parIm | input | PAR_W | Imaginary part of the parity engine's output bin |
| errFlags | output | NUM_ENG | Per-engine energy mismatch flags |
| uncorrectable | output | 1 | More than one engine flagged in this frame |
| rdValid | output | 1 | A replayed bin is on rdReBus/rdImBus |
| rdIndex | output | IDX_W | Bin index of the replayed bin |
| rdReBus | output | NUM_ENG*OUT_W | Real parts of the replayed (possibly repaired) bins |
| rdImBus | output | NUM_ENG*OUT_W | Imaginary parts of the replayed (possibly repaired) bins |
| frameDone | output | 1 | One-cycle pulse after the replay ends |

## Verification
The flags are due one cycle after the edge that accepts the 16th beat. Replay bin i is due i cycles after that, and frameDone is due sixteen cycles after the flags. A frameStart clears the flags one cycle after it is sampled.

The bench models the same schedule with a phase counter that advances on each rising edge, using only the sampled port values. It compares every output with that model at each falling edge, so every due cycle, and also every cycle in which an output must hold still, is checked.

Frames with gaps, frames restarted during replay, and sampleValid pulses outside a frame confirm that beat acceptance follows the schedule.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // Frame length of each transform engine; bins are indexed 0..FRAME_LEN-1.
  localparam int FRAME_LEN = 16;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  // Unnormalised transform: output energy = FRAME_LEN * input energy.
  localparam int GAIN_SHIFT = $clog2(FRAME_LEN);

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic             clearAll;   // wipe accumulators and flags
    logic             accumEn;    // accept the current beat
    logic [IDX_W-1:0] wrIdx;      // bin slot written by the beat
    logic             evalFlags;  // latch the energy comparisons
    logic [IDX_W-1:0] rdIdx;      // bin slot being replayed
  } pccCtrl_t;

endpackage

// File: rtl/pcc_energy.sv
module pcc_energy
  import pcc_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 13,
  parameter int EN_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    accumEn,
  input  logic signed [IN_W-1:0]  inRe,
  input  logic signed [IN_W-1:0]  inIm,
  input  logic signed [OUT_W-1:0] outRe,
  input  logic signed [OUT_W-1:0] outIm,
  input  logic [EN_W-1:0]         thresh,
  output logic                    mismatch
);

  localparam int ISQ_W = 2 * IN_W;
  localparam int OSQ_W = 2 * OUT_W;

  logic signed [ISQ_W-1:0] inReSq, inImSq;
  logic signed [OSQ_W-1:0] outReSq, outImSq;
  logic [EN_W-1:0] inMag, outMag;
  logic [EN_W-1:0] accIn, accOut;
  logic [EN_W-1:0] scaledIn, gap;

  // One squaring per component, per sample and stream.
  assign inReSq  = inRe * inRe;
  assign inImSq  = inIm * inIm;
  assign outReSq = outRe * outRe;
  assign outImSq = outIm * outIm;

  assign inMag  = EN_W'($unsigned(inReSq))  + EN_W'($unsigned(inImSq));
  assign outMag = EN_W'($unsigned(outReSq)) + EN_W'($unsigned(outImSq));

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      accIn  <= '0;
      accOut <= '0;
    end else if (accumEn) begin
      accIn  <= accIn + inMag;
      accOut <= accOut + outMag;
    end
  end

  assign scaledIn = accIn << GAIN_SHIFT;
  assign gap      = (accOut >= scaledIn) ? (accOut - scaledIn) : (scaledIn - accOut);
  assign mismatch = (gap > thresh);

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int NUM_ENG = 4,
  parameter int IN_W    = 8,
  parameter int OUT_W   = 13,
  parameter int PAR_W   = 15,
  parameter int EN_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pccCtrl_t                   ctrl,
  input  logic [EN_W-1:0]            thresh,
  input  logic [NUM_ENG*IN_W-1:0]    inReBus,
  input  logic [NUM_ENG*IN_W-1:0]    inImBus,
  input  logic [NUM_ENG*OUT_W-1:0]   outReBus,
  input  logic [NUM_ENG*OUT_W-1:0]   outImBus,
  input  logic [PAR_W-1:0]           parRe,
  input  logic [PAR_W-1:0]           parIm,
  output logic [NUM_ENG-1:0]         errFlags,
  output logic                       uncorrectable,
  output logic [NUM_ENG*OUT_W-1:0]   rdReBus,
  output logic [NUM_ENG*OUT_W-1:0]   rdImBus
);

  logic [OUT_W-1:0] bufRe [NUM_ENG][FRAME_LEN];
  logic [OUT_W-1:0] bufIm [NUM_ENG][FRAME_LEN];
  logic [PAR_W-1:0] parBufRe [FRAME_LEN];
  logic [PAR_W-1:0] parBufIm [FRAME_LEN];
  logic [NUM_ENG-1:0] mismatch;
  logic [OUT_W-1:0] rdRe [NUM_ENG];
  logic [OUT_W-1:0] rdIm [NUM_ENG];

  // Per-engine energy checkers and frame stores.
  for (genvar g = 0; g < NUM_ENG; g++) begin : gEng
    pcc_energy #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .EN_W (EN_W)
    ) u_energy (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (ctrl.clearAll),
      .accumEn (ctrl.accumEn),
      .inRe    (inReBus[g*IN_W +: IN_W]),
      .inIm    (inImBus[g*IN_W +: IN_W]),
      .outRe   (outReBus[g*OUT_W +: OUT_W]),
      .outIm   (outImBus[g*OUT_W +: OUT_W]),
      .thresh  (thresh),
      .mismatch(mismatch[g])
    );

    always_ff @(posedge clk) begin
      if (ctrl.accumEn) begin
        bufRe[g][ctrl.wrIdx] <= outReBus[g*OUT_W +: OUT_W];
        bufIm[g][ctrl.wrIdx] <= outImBus[g*OUT_W +: OUT_W];
      end
    end

    assign rdReBus[g*OUT_W +: OUT_W] = rdRe[g];
    assign rdImBus[g*OUT_W +: OUT_W] = rdIm[g];
  end

  always_ff @(posedge clk) begin
    if (ctrl.accumEn) begin
      parBufRe[ctrl.wrIdx] <= parRe;
      parBufIm[ctrl.wrIdx] <= parIm;
    end
  end

  // Flag register: latched once both energy sums are complete.
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      errFlags      <= '0;
      uncorrectable <= 1'b0;
    end else if (ctrl.evalFlags) begin
      errFlags      <= mismatch;
      uncorrectable <= ($countones(mismatch) > 1);
    end
  end

  // Replay path: a lone flagged engine is rebuilt from parity minus peers.
  always_comb begin
    logic signed [PAR_W-1:0] peersRe, peersIm, fixRe, fixIm;
    for (int e = 0; e < NUM_ENG; e++) begin
      peersRe = '0;
      peersIm = '0;
      for (int j = 0; j < NUM_ENG; j++) begin
        if (j != e) begin
          peersRe = peersRe + PAR_W'($signed(bufRe[j][ctrl.rdIdx]));
          peersIm = peersIm + PAR_W'($signed(bufIm[j][ctrl.rdIdx]));
        end
      end
      fixRe = $signed(parBufRe[ctrl.rdIdx]) - peersRe;
      fixIm = $signed(parBufIm[ctrl.rdIdx]) - peersIm;
      if (errFlags[e] && !uncorrectable) begin
        rdRe[e] = fixRe[OUT_W-1:0];
        rdIm[e] = fixIm[OUT_W-1:0];
      end else begin
        rdRe[e] = bufRe[e][ctrl.rdIdx];
        rdIm[e] = bufIm[e][ctrl.rdIdx];
      end
    end
  end

endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             sampleValid,
  output pccCtrl_t         ctrl,
  output logic             rdValid,
  output logic [IDX_W-1:0] rdIndex,
  output logic             frameDone
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_CHECK,
    ST_EMIT,
    ST_DONE
  } pccState_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  pccState_t state;
  logic [IDX_W-1:0] cnt;
  logic takeBeat;

  assign takeBeat = (state == ST_COLLECT) && sampleValid && !frameStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (frameStart) begin
      state <= ST_COLLECT;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: if (takeBeat) begin
          cnt <= cnt + 1'b1;          // wraps to 0 after the last bin
          if (cnt == LAST_IDX) state <= ST_CHECK;
        end
        ST_CHECK: state <= ST_EMIT;
        ST_EMIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.clearAll  = frameStart;
    ctrl.accumEn   = takeBeat;
    ctrl.wrIdx     = cnt;
    ctrl.evalFlags = (state == ST_CHECK);
    ctrl.rdIdx     = cnt;
  end

  assign rdValid   = (state == ST_EMIT);
  assign rdIndex   = cnt;
  assign frameDone = (state == ST_DONE);

endmodule

// File: rtl/pcc_parity_guard.sv
module pcc_parity_guard
  import pcc_pkg::*;
#(
  parameter int NUM_ENG = 4,
  parameter int IN_W    = 8,
  parameter int OUT_W   = 13,
  parameter int EN_W    = 32,
  localparam int PAR_W  = OUT_W + $clog2(NUM_ENG)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameStart,
  input  logic                     sampleValid,
  input  logic [EN_W-1:0]          thresh,
  input  logic [NUM_ENG*IN_W-1:0]  inReBus,
  input  logic [NUM_ENG*IN_W-1:0]  inImBus,
  input  logic [NUM_ENG*OUT_W-1:0] outReBus,
  input  logic [NUM_ENG*OUT_W-1:0] outImBus,
  input  logic [PAR_W-1:0]         parRe,
  input  logic [PAR_W-1:0]         parIm,
  output logic [NUM_ENG-1:0]       errFlags,
  output logic                     uncorrectable,
  output logic                     rdValid,
  output logic [IDX_W-1:0]         rdIndex,
  output logic [NUM_ENG*OUT_W-1:0] rdReBus,
  output logic [NUM_ENG*OUT_W-1:0] rdImBus,
  output logic                     frameDone
);

  pccCtrl_t ctrl;

  pcc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .sampleValid(sampleValid),
    .ctrl       (ctrl),
    .rdValid    (rdValid),
    .rdIndex    (rdIndex),
    .frameDone  (frameDone)
  );

  pcc_datapath #(
    .NUM_ENG(NUM_ENG),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .PAR_W  (PAR_W),
    .EN_W   (EN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .thresh       (thresh),
    .inReBus      (inReBus),
    .inImBus      (inImBus),
    .outReBus     (outReBus),
    .outImBus     (outImBus),
    .parRe        (parRe),
    .parIm        (parIm),
    .errFlags     (errFlags),
    .uncorrectable(uncorrectable),
    .rdReBus      (rdReBus),
    .rdImBus      (rdImBus)
  );

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int NUM_ENG = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic [NUM_ENG-1:0] errFlags,
  input logic               uncorrectable,
  input logic               rdValid,
  input logic [IDX_W-1:0]   rdIndex,
  input logic               frameDone
);

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(rdValid) && ($past(rdIndex) == IDX_W'(FRAME_LEN - 1))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R5

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |-> (rdIndex == IDX_W'($past(rdIndex) + 1'b1))); // R5

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid)) |-> ($stable(errFlags) && $stable(uncorrectable))); // R3

  AST_UNC_MULTI: assert property (@(posedge clk) disable iff (!rstN)
    uncorrectable |-> ($countones(errFlags) > 1)); // R3

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameStart) |-> (errFlags == '0 && !uncorrectable && !rdValid)); // R6

endmodule

bind pcc_parity_guard pcc_checker #(.NUM_ENG(NUM_ENG)) u_pccChecker (
  .clk          (clk),
  .rstN         (rstN),
  .frameStart   (frameStart),
  .errFlags     (errFlags),
  .uncorrectable(uncorrectable),
  .rdValid      (rdValid),
  .rdIndex      (rdIndex),
  .frameDone    (frameDone)
);

// File: tb/tb_pcc_parity_guard.sv
module tb_pcc_parity_guard;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int IW = 8;
  localparam int OW = 13;
  localparam int PW = 15;
  localparam int EW = 32;
  localparam int FL = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic sampleValid = 1'b0;
  logic [EW-1:0] thresh = '0;
  logic [NE*IW-1:0] inReBus = '0, inImBus = '0;
  logic [NE*OW-1:0] outReBus = '0, outImBus = '0;
  logic [PW-1:0] parRe = '0, parIm = '0;
  logic [NE-1:0] errFlags;
  logic uncorrectable, rdValid, frameDone;
  logic [3:0] rdIndex;
  logic [NE*OW-1:0] rdReBus, rdImBus;

  pcc_parity_guard dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .sampleValid(sampleValid),
    .thresh(thresh), .inReBus(inReBus), .inImBus(inImBus),
    .outReBus(outReBus), .outImBus(outImBus), .parRe(parRe), .parIm(parIm),
    .errFlags(errFlags), .uncorrectable(uncorrectable), .rdValid(rdValid),
    .rdIndex(rdIndex), .rdReBus(rdReBus), .rdImBus(rdImBus), .frameDone(frameDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Stimulus frame: clean transform outputs plus optional faults.
  int xr[NE][FL], xi[NE][FL];
  int yr[NE][FL], yi[NE][FL];
  int fr[NE][FL], fi[NE][FL];

  task automatic buildFrame(input int seed, input bit impulse);
    for (int e = 0; e < NE; e++) begin
      for (int n = 0; n < FL; n++) begin
        if (impulse) begin
          xr[e][n] = (n == 0) ? 10 : 0;
          xi[e][n] = 0;
        end else begin
          xr[e][n] = ((seed * 37 + n * 11 + e * 23) % 31) - 15;
          xi[e][n] = ((seed * 53 + n * 7 + e * 13 + 5) % 31) - 15;
        end
      end
      for (int k = 0; k < FL; k++) begin
        real ar, ai;
        ar = 0.0;
        ai = 0.0;
        for (int n = 0; n < FL; n++) begin
          real ang;
          ang = 2.0 * 3.14159265358979 * real'(k * n) / real'(FL);
          ar += real'(xr[e][n]) * $cos(ang) - real'(xi[e][n]) * $sin(ang);
          ai += real'(xr[e][n]) * $sin(ang) + real'(xi[e][n]) * $cos(ang);
        end
        yr[e][k] = int'(ar);
        yi[e][k] = int'(ai);
        fr[e][k] = yr[e][k];
        fi[e][k] = yi[e][k];
      end
    end
  endtask

  task automatic driveBeat(input int n);
    int sr, si;
    sr = 0;
    si = 0;
    for (int e = 0; e < NE; e++) begin
      inReBus[e*IW +: IW]  = IW'(xr[e][n]);
      inImBus[e*IW +: IW]  = IW'(xi[e][n]);
      outReBus[e*OW +: OW] = OW'(fr[e][n]);
      outImBus[e*OW +: OW] = OW'(fi[e][n]);
      sr += yr[e][n];
      si += yi[e][n];
    end
    parRe = PW'(sr);
    parIm = PW'(si);
  endtask

  task automatic driveJunk(input int s);
    inReBus  = NE*IW'(s * 97 + 3);
    inImBus  = NE*IW'(s * 31 + 9);
    outReBus = NE*OW'(s * 1237 + 77);
    outImBus = NE*OW'(s * 911 + 5);
    parRe    = PW'(s * 555);
    parIm    = PW'(s * 321);
  endtask

  task automatic pulseStart();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic feedBeats(input bit gapped, input int count);
    for (int n = 0; n < count; n++) begin
      if (gapped && (n % 4 == 2)) begin
        sampleValid = 1'b0;
        driveJunk(n);
        @(negedge clk);
      end
      driveBeat(n);
      sampleValid = 1'b1;
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic idleCycles(input int n, input bit junk);
    for (int i = 0; i < n; i++) begin
      sampleValid = junk;
      if (junk) driveJunk(i + 40);
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  // Behavioural reference: phase advances at each rising edge from port values.
  int mPhase = 0;  // 0 idle, 1 collect, 2 check, 3 replay, 4 done
  int mCnt = 0, mIdx = 0;
  longint mEin[NE], mEout[NE];
  int mOr[NE][FL], mOi[NE][FL];
  int mPr[FL], mPi[FL];
  bit [NE-1:0] mFlags = '0;
  bit mUnc = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mFlags = '0; mUnc = 1'b0; mCnt = 0;
    end else if (frameStart) begin
      mPhase = 1; mCnt = 0; mFlags = '0; mUnc = 1'b0;
      for (int e = 0; e < NE; e++) begin mEin[e] = 0; mEout[e] = 0; end
    end else begin
      case (mPhase)
        1: if (sampleValid) begin
          for (int e = 0; e < NE; e++) begin
            int a, b, c, d;
            a = $signed(inReBus[e*IW +: IW]);
            b = $signed(inImBus[e*IW +: IW]);
            c = $signed(outReBus[e*OW +: OW]);
            d = $signed(outImBus[e*OW +: OW]);
            mEin[e] += longint'(a * a + b * b);
            mEout[e] += longint'(c * c + d * d);
            mOr[e][mCnt] = c;
            mOi[e][mCnt] = d;
          end
          mPr[mCnt] = $signed(parRe);
          mPi[mCnt] = $signed(parIm);
          mCnt++;
          if (mCnt == FL) mPhase = 2;
        end
        2: begin
          int nf;
          nf = 0;
          for (int e = 0; e < NE; e++) begin
            longint g;
            g = mEout[e] - 16 * mEin[e];
            if (g < 0) g = -g;
            mFlags[e] = (g > longint'(thresh));
            if (mFlags[e]) nf++;
          end
          mUnc = (nf > 1);
          mPhase = 3;
          mIdx = 0;
        end
        3: if (mIdx == FL - 1) mPhase = 4; else mIdx++;
        4: mPhase = 0;
        default: mPhase = 0;
      endcase
    end
  end

  int cleanEng = -1;  // engine whose repaired output must equal the clean transform

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(rdValid == (mPhase == 3), "R5 rdValid", rdValid, mPhase == 3);
      chk(frameDone == (mPhase == 4), "R5 frameDone", frameDone, mPhase == 4);
      chk(errFlags == mFlags, "R1 errFlags", errFlags, mFlags);
      chk(uncorrectable == mUnc, "R3 uncorrectable", uncorrectable, mUnc);
      if (mPhase == 3) begin
        chk(rdIndex == 4'(mIdx), "R5 rdIndex", rdIndex, mIdx);
        for (int e = 0; e < NE; e++) begin
          int er, ei, ar, ai;
          logic signed [OW-1:0] wr, wi;
          ar = $signed(rdReBus[e*OW +: OW]);
          ai = $signed(rdImBus[e*OW +: OW]);
          if (mFlags[e] && !mUnc) begin
            int pr, pi;
            pr = mPr[mIdx];
            pi = mPi[mIdx];
            for (int j = 0; j < NE; j++)
              if (j != e) begin pr -= mOr[j][mIdx]; pi -= mOi[j][mIdx]; end
            wr = OW'(pr);
            wi = OW'(pi);
            er = wr;
            ei = wi;
            chk(ar == er && ai == ei, "R2 repaired bin", ar, er);
            if (e == cleanEng)
              chk(ar == yr[e][mIdx] && ai == yi[e][mIdx], "R2 matches clean transform", ar, yr[e][mIdx]);
          end else begin
            er = mOr[e][mIdx];
            ei = mOi[e][mIdx];
            chk(ar == er && ai == ei, "R3 passthrough bin", ar, er);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset values
    chk(errFlags == '0, "R7 errFlags", errFlags, 0);
    chk(!uncorrectable, "R7 uncorrectable", uncorrectable, 0);
    chk(!rdValid, "R7 rdValid", rdValid, 0);
    chk(!frameDone, "R7 frameDone", frameDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: clean random frame, no flag
    thresh = 32'd8192;
    buildFrame(1, 1'b0);
    pulseStart(); feedBeats(1'b0, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b0000, "R1 clean frame flags", errFlags, 0);

    // R2: single fault on engine 1, repaired
    buildFrame(2, 1'b0);
    fr[1][5] += 2000;
    cleanEng = 1;
    pulseStart(); feedBeats(1'b0, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b0010, "R2 single flag", errFlags, 4'b0010);

    // R3: two faults, uncorrectable passthrough
    buildFrame(3, 1'b0);
    fr[0][2] += 2000;
    fi[3][9] -= 2000;
    cleanEng = -1;
    pulseStart(); feedBeats(1'b0, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b1001 && uncorrectable, "R3 double fault", errFlags, 4'b1001);

    // R1 boundary: gap of 21 equals thresh, not flagged
    buildFrame(0, 1'b1);
    fr[2][0] += 1;
    thresh = 32'd21;
    pulseStart(); feedBeats(1'b0, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b0000, "R1 gap equal to thresh", errFlags, 0);

    // R1 boundary: thresh one below gap, flagged and repaired exactly
    thresh = 32'd20;
    cleanEng = 2;
    pulseStart(); feedBeats(1'b0, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b0100, "R1 gap above thresh", errFlags, 4'b0100);

    // R4 gapped frame; R8 junk beats during replay and idle
    thresh = 32'd8192;
    buildFrame(4, 1'b0);
    fr[3][15] += 2000;
    cleanEng = 3;
    pulseStart(); feedBeats(1'b1, FL); idleCycles(30, 1'b1);
    chk(errFlags == 4'b1000, "R4 gapped frame flag", errFlags, 4'b1000);
    chk(!rdValid && !frameDone, "R8 junk beats in idle", rdValid, 0);

    // R6: restart during replay clears flags
    buildFrame(5, 1'b0);
    fr[0][7] += 2000;
    cleanEng = 0;
    pulseStart(); feedBeats(1'b0, FL);
    repeat (4) @(negedge clk);
    chk(errFlags == 4'b0001 && rdValid, "R6 flags before restart", errFlags, 4'b0001);
    pulseStart();
    chk(errFlags == 4'b0000 && !rdValid, "R6 cleared by restart", errFlags, 0);
    buildFrame(6, 1'b0);
    cleanEng = -1;
    feedBeats(1'b1, FL); idleCycles(22, 1'b0);
    chk(errFlags == 4'b0000, "R6 clean frame after restart", errFlags, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule